// File: doc/BRIEF.md
# Gated Drive-Port Register Front End with DMA Launch

This block sits between a processor register bus and an attached disk drive. It decodes single-cycle register writes and combinational register reads. It holds the drive's task-file bytes, which are the parameters of the next drive command. It issues command strobes to the drive. It also holds a small DMA setup: address, length and direction. A transfer is launched through a request/done handshake with an external data mover.

Access to the drive registers is protected by an unlock gate. The gate opens only when a specific key word is written to the gate register, and closes only when a second key word is written there. While the gate is closed, drive-register writes vanish and drive-register reads return all ones. A transfer needs two steps. First an arm register must hold 1. Then writing 1 to the go register raises the request. The mover's done pulse records the byte count and drops the request.

Register word addresses (4 bits) are fixed as follows:
- Drive registers, gated, 0 to 6: feature (0), sector count (1), LBA low (2), LBA mid (3), LBA high (4), device/head (5), command (6). Reading address 6 returns the drive status byte.
- DMA registers, not gated: DMA address (8), DMA length (9), direction (10, bit 0), arm (11), go (12, bit 0), bytes moved (13, read only).
- Gate (14): reads 1 when open and 0 when closed.
- Addresses 7 and 15 read as zero.

Top module: `dmafe_top`

## Requirements
- R1: After synchronous reset the gate is closed. Addresses 8 to 13 all read 0, `dma_req` and `cmd_valid` are low, and the task-file outputs are 0.
- R2: Writing 0x001FFFFF to address 14 opens the gate, and writing 0x000042FE closes it. Any other value written there leaves the gate state as it was. Address 14 reads 1 when the gate is open and 0 when it is closed.
- R3: While the gate is closed, reads of addresses 0 to 6 return 0xFFFFFFFF and writes to them change nothing. While the gate is open, address 6 reads the drive status byte, zero-extended.
- R4: With the gate open, a write to addresses 0 to 5 is stored only when `drv_can_write` is high. Only the low 8 bits of the write are kept, and reads return them zero-extended.
- R5: With the gate open, a write to address 6 produces a one-cycle `cmd_valid` pulse carrying the low byte on `cmd_code`, in the cycle after the write. This happens when `drv_can_write` is high, or when the byte equals the no-op code (default 0x00). Otherwise no pulse is produced.
- R6: When idle, writing 1 to address 12 while address 11 holds 1 raises `dma_req` and clears the bytes-moved register to 0. `dma_req` stays high until `dma_done`.
- R7: When idle, writing 1 to address 12 while address 11 holds any value other than 1 starts nothing: `dma_req` stays low and address 12 reads 0.
- R8: A `dma_done` pulse during a transfer stores `dma_bytes` into address 13 and returns the go register and `dma_req` to 0. A `dma_done` pulse while idle has no effect.
- R9: While `dma_req` is high, writes to addresses 8 to 12 are ignored, and `dma_addr`, `dma_len` and `dma_dir` hold steady.
- R10: The DMA registers (8 to 12) are writable and readable whether or not the gate is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register word address for writes |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Register word address for reads |
| rd_data | output | 32 | Combinational read data for `rd_addr` |
| drv_can_write | input | 1 | Drive reports it accepts task-file writes |
| drv_status | input | 8 | Drive status byte, returned at address 6 |
| tf_feature | output | 8 | Task-file feature byte |
| tf_count | output | 8 | Task-file sector count byte |
| tf_lba | output | 24 | Task-file LBA, high byte first |
| tf_device | output | 8 | Task-file device/head byte |
| cmd_valid | output | 1 | One-cycle command strobe to the drive |
| cmd_code | output | 8 | Command byte qualified by `cmd_valid` |
| dma_req | output | 1 | Transfer request to the data mover |
| dma_addr | output | 32 | Transfer memory address |
| dma_len | output | 32 | Transfer length in bytes |
| dma_dir | output | 1 | Transfer direction |
| dma_done | input | 1 | Mover completion pulse |
| dma_bytes | input | 32 | Bytes moved, valid with `dma_done` |

## Verification
The bench builds the block with its default parameters:
- the two 32-bit gate keys;
- the no-op code 0x00.

Since the no-op code is zero, a zero command byte written while the drive refuses writes still reaches the drive, whereas a nonzero byte is refused. The key defaults let the bench write near-miss values to the gate and show that they neither open nor close it.

// File: rtl/dmafe_pkg.sv
package dmafe_pkg;

    localparam int DATA_W  = 32;
    localparam int REG_AW  = 4;
    localparam int BYTE_W  = 8;
    localparam int TF_N    = 6;

    typedef enum logic [REG_AW-1:0] {
        RG_FEAT    = 4'd0,
        RG_SECT    = 4'd1,
        RG_LBA_LO  = 4'd2,
        RG_LBA_MID = 4'd3,
        RG_LBA_HI  = 4'd4,
        RG_HEAD    = 4'd5,
        RG_CMD     = 4'd6,
        RG_RSVD7   = 4'd7,
        RG_XADDR   = 4'd8,
        RG_XLEN    = 4'd9,
        RG_XDIR    = 4'd10,
        RG_ARM     = 4'd11,
        RG_GO      = 4'd12,
        RG_MOVED   = 4'd13,
        RG_GATE    = 4'd14,
        RG_RSVD15  = 4'd15
    } reg_sel_e;

    typedef struct packed {
        logic              we;
        logic [REG_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    typedef struct packed {
        logic [BYTE_W-1:0] feature;
        logic [BYTE_W-1:0] count;
        logic [BYTE_W-1:0] lba_lo;
        logic [BYTE_W-1:0] lba_mid;
        logic [BYTE_W-1:0] lba_hi;
        logic [BYTE_W-1:0] device;
    } taskfile_t;

    typedef struct packed {
        logic [DATA_W-1:0] addr;
        logic [DATA_W-1:0] len;
        logic              dir;
    } dma_cfg_t;

    function automatic logic is_drive_reg(input logic [REG_AW-1:0] a);
        return a <= RG_CMD;
    endfunction

    function automatic logic [DATA_W-1:0] zext_byte(input logic [BYTE_W-1:0] b);
        return {{(DATA_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/dmafe_gate.sv
module dmafe_gate
    import dmafe_pkg::*;
#(
    parameter logic [DATA_W-1:0] OPEN_KEY  = 32'h001F_FFFF,
    parameter logic [DATA_W-1:0] CLOSE_KEY = 32'h0000_42FE
) (
    input  logic    clk,
    input  logic    rst,
    input  wr_req_t wr,
    output logic    open_o
);

    logic open_q;
    logic gate_wr;

    assign gate_wr = wr.we && (wr.addr == RG_GATE);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (gate_wr) begin
            if (wr.data == OPEN_KEY) begin
                open_q <= 1'b1;
            end else if (wr.data == CLOSE_KEY) begin
                open_q <= 1'b0;
            end
        end
    end

    assign open_o = open_q;

    // R2: the gate only moves on a write to the gate register
    p_gate_key_only_r2: assert property (@(posedge clk) disable iff (rst)
        (open_q != $past(open_q)) |-> $past(gate_wr));

endmodule

// File: rtl/dmafe_taskfile.sv
module dmafe_taskfile
    import dmafe_pkg::*;
#(
    parameter logic [BYTE_W-1:0] NOP_CODE = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_we,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              open_i,
    input  logic              can_write,
    output taskfile_t         tf_o,
    output logic              cmd_valid_o,
    output logic [BYTE_W-1:0] cmd_code_o
);

    logic [BYTE_W-1:0] tf_byte [TF_N];
    logic              tf_wr_ok;
    logic              cmd_ok;
    logic              cmd_valid_q;
    logic [BYTE_W-1:0] cmd_code_q;

    assign tf_wr_ok = wr_we && open_i && can_write;

    for (genvar g = 0; g < TF_N; g++) begin : g_tf
        always_ff @(posedge clk) begin
            if (rst) begin
                tf_byte[g] <= '0;
            end else if (tf_wr_ok && (wr_addr == REG_AW'(g))) begin
                tf_byte[g] <= wr_byte;
            end
        end
    end

    assign cmd_ok = wr_we && open_i && (wr_addr == RG_CMD)
                    && (can_write || (wr_byte == NOP_CODE));

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid_q <= 1'b0;
            cmd_code_q  <= '0;
        end else begin
            cmd_valid_q <= cmd_ok;
            if (cmd_ok) begin
                cmd_code_q <= wr_byte;
            end
        end
    end

    always_comb begin
        tf_o.feature = tf_byte[RG_FEAT];
        tf_o.count   = tf_byte[RG_SECT];
        tf_o.lba_lo  = tf_byte[RG_LBA_LO];
        tf_o.lba_mid = tf_byte[RG_LBA_MID];
        tf_o.lba_hi  = tf_byte[RG_LBA_HI];
        tf_o.device  = tf_byte[RG_HEAD];
    end

    assign cmd_valid_o = cmd_valid_q;
    assign cmd_code_o  = cmd_code_q;

    // R3: a closed gate freezes the task file
    p_locked_tf_r3: assert property (@(posedge clk) disable iff (rst)
        !open_i |=> $stable(tf_o));

    // R5: a command strobe only follows a cycle with the gate open
    p_cmd_gate_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid_q |-> $past(open_i));

    // R5: the strobe is a single-cycle pulse per write
    p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_q && !$past(wr_we)) |-> 1'b0 || !cmd_valid_q || $past(cmd_ok));

endmodule

// File: rtl/dmafe_dma.sv
module dmafe_dma
    import dmafe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           wr,
    input  logic              done_i,
    input  logic [DATA_W-1:0] bytes_i,
    output dma_cfg_t          cfg_o,
    output logic [DATA_W-1:0] arm_o,
    output logic              go_o,
    output logic [DATA_W-1:0] moved_o
);

    dma_cfg_t          cfg_q;
    logic [DATA_W-1:0] arm_q;
    logic              go_q;
    logic [DATA_W-1:0] moved_q;
    logic              idle_wr;

    assign idle_wr = wr.we && !go_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            arm_q   <= '0;
            go_q    <= 1'b0;
            moved_q <= '0;
        end else if (go_q) begin
            if (done_i) begin
                go_q    <= 1'b0;
                moved_q <= bytes_i;
            end
        end else if (idle_wr) begin
            unique case (wr.addr)
                RG_XADDR: cfg_q.addr <= wr.data;
                RG_XLEN:  cfg_q.len  <= wr.data;
                RG_XDIR:  cfg_q.dir  <= wr.data[0];
                RG_ARM:   arm_q      <= wr.data;
                RG_GO: begin
                    if ((wr.data == DATA_W'(1)) && (arm_q == DATA_W'(1))) begin
                        go_q    <= 1'b1;
                        moved_q <= '0;
                    end else begin
                        go_q    <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign cfg_o   = cfg_q;
    assign arm_o   = arm_q;
    assign go_o    = go_q;
    assign moved_o = moved_q;

    // R6: the request holds until the mover reports completion
    p_req_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (go_q && !done_i) |=> go_q);

    // R6: a new transfer starts with the moved count cleared
    p_start_clear_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(go_q) |-> (moved_q == '0));

    // R8: completion drops the request and records the count
    p_done_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (go_q && done_i) |=> (!go_q && (moved_q == $past(bytes_i))));

    // R9: setup is frozen while a transfer runs
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        (go_q && !done_i) |=> ($stable(cfg_q) && $stable(arm_q)));

    // R7: an unarmed go never raises the request
    p_no_unarmed_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(go_q) |-> ($past(arm_q) == DATA_W'(1)));

endmodule

// File: rtl/dmafe_top.sv
module dmafe_top
    import dmafe_pkg::*;
#(
    parameter logic [DATA_W-1:0] OPEN_KEY  = 32'h001F_FFFF,
    parameter logic [DATA_W-1:0] CLOSE_KEY = 32'h0000_42FE,
    parameter logic [BYTE_W-1:0] NOP_CODE  = 8'h00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              drv_can_write,
    input  logic [BYTE_W-1:0] drv_status,
    output logic [BYTE_W-1:0] tf_feature,
    output logic [BYTE_W-1:0] tf_count,
    output logic [3*BYTE_W-1:0] tf_lba,
    output logic [BYTE_W-1:0] tf_device,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_code,
    output logic              dma_req,
    output logic [DATA_W-1:0] dma_addr,
    output logic [DATA_W-1:0] dma_len,
    output logic              dma_dir,
    input  logic              dma_done,
    input  logic [DATA_W-1:0] dma_bytes
);

    wr_req_t           wr;
    logic              open;
    taskfile_t         tf;
    dma_cfg_t          cfg;
    logic [DATA_W-1:0] arm;
    logic              go;
    logic [DATA_W-1:0] moved;

    assign wr = '{we: wr_en, addr: wr_addr, data: wr_data};

    dmafe_gate #(
        .OPEN_KEY  (OPEN_KEY),
        .CLOSE_KEY (CLOSE_KEY)
    ) u_gate (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .open_o (open)
    );

    dmafe_taskfile #(
        .NOP_CODE (NOP_CODE)
    ) u_tf (
        .clk         (clk),
        .rst         (rst),
        .wr_we       (wr_en),
        .wr_addr     (wr_addr),
        .wr_byte     (wr_data[BYTE_W-1:0]),
        .open_i      (open),
        .can_write   (drv_can_write),
        .tf_o        (tf),
        .cmd_valid_o (cmd_valid),
        .cmd_code_o  (cmd_code)
    );

    dmafe_dma u_dma (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .done_i  (dma_done),
        .bytes_i (dma_bytes),
        .cfg_o   (cfg),
        .arm_o   (arm),
        .go_o    (go),
        .moved_o (moved)
    );

    always_comb begin
        rd_data = '0;
        if (is_drive_reg(rd_addr) && !open) begin
            rd_data = '1;
        end else begin
            unique case (rd_addr)
                RG_FEAT:    rd_data = zext_byte(tf.feature);
                RG_SECT:    rd_data = zext_byte(tf.count);
                RG_LBA_LO:  rd_data = zext_byte(tf.lba_lo);
                RG_LBA_MID: rd_data = zext_byte(tf.lba_mid);
                RG_LBA_HI:  rd_data = zext_byte(tf.lba_hi);
                RG_HEAD:    rd_data = zext_byte(tf.device);
                RG_CMD:     rd_data = zext_byte(drv_status);
                RG_XADDR:   rd_data = cfg.addr;
                RG_XLEN:    rd_data = cfg.len;
                RG_XDIR:    rd_data = DATA_W'(cfg.dir);
                RG_ARM:     rd_data = arm;
                RG_GO:      rd_data = DATA_W'(go);
                RG_MOVED:   rd_data = moved;
                RG_GATE:    rd_data = DATA_W'(open);
                default:    rd_data = '0;
            endcase
        end
    end

    assign tf_feature = tf.feature;
    assign tf_count   = tf.count;
    assign tf_lba     = {tf.lba_hi, tf.lba_mid, tf.lba_lo};
    assign tf_device  = tf.device;
    assign dma_req    = go;
    assign dma_addr   = cfg.addr;
    assign dma_len    = cfg.len;
    assign dma_dir    = cfg.dir;

    // R3: closed gate reads of drive registers are all ones
    p_closed_read_r3: assert property (@(posedge clk) disable iff (rst)
        (!open && is_drive_reg(rd_addr)) |-> (rd_data == '1));

endmodule

// File: tb/tb_dmafe_top.sv
module tb_dmafe_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [3:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  rd_addr;
    logic [31:0] rd_data;
    logic        drv_can_write;
    logic [7:0]  drv_status;
    logic [7:0]  tf_feature, tf_count, tf_device, cmd_code;
    logic [23:0] tf_lba;
    logic        cmd_valid, dma_req, dma_dir, dma_done;
    logic [31:0] dma_addr, dma_len, dma_bytes;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    dmafe_top dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .drv_can_write(drv_can_write),
        .drv_status(drv_status), .tf_feature(tf_feature), .tf_count(tf_count),
        .tf_lba(tf_lba), .tf_device(tf_device), .cmd_valid(cmd_valid),
        .cmd_code(cmd_code), .dma_req(dma_req), .dma_addr(dma_addr),
        .dma_len(dma_len), .dma_dir(dma_dir), .dma_done(dma_done),
        .dma_bytes(dma_bytes)
    );

    // {we, waddr, wdata, raddr, expected read}
    localparam int NV = 16;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 4'd0,  32'h0,         4'd14, 32'h0},          // R1 gate closed
        {1'b0, 4'd0,  32'h0,         4'd0,  32'hFFFF_FFFF},  // R3 closed read
        {1'b1, 4'd14, 32'h001F_FFFE, 4'd14, 32'h0},          // R2 near miss
        {1'b1, 4'd14, 32'h001F_FFFF, 4'd14, 32'h1},          // R2 open
        {1'b1, 4'd0,  32'h1234_56C3, 4'd0,  32'h0000_00C3},  // R4 low byte
        {1'b1, 4'd2,  32'hFFFF_FF11, 4'd2,  32'h0000_0011},  // R4
        {1'b0, 4'd0,  32'h0,         4'd6,  32'h0000_005A},  // R3 status
        {1'b1, 4'd14, 32'h0000_42FE, 4'd14, 32'h0},          // R2 close
        {1'b1, 4'd0,  32'h0000_0077, 4'd14, 32'h0},          // R3 dropped
        {1'b1, 4'd10, 32'h0000_0001, 4'd10, 32'h1},          // R10 closed
        {1'b1, 4'd14, 32'h001F_FFFF, 4'd0,  32'h0000_00C3},  // R3 kept
        {1'b1, 4'd14, 32'h0000_42FF, 4'd14, 32'h1},          // R2 near miss
        {1'b1, 4'd8,  32'h8000_1000, 4'd8,  32'h8000_1000},  // R10
        {1'b1, 4'd9,  32'h0000_0200, 4'd9,  32'h0000_0200},  // R10
        {1'b1, 4'd11, 32'h0000_0002, 4'd11, 32'h2},          // R10
        {1'b1, 4'd12, 32'h0000_0001, 4'd12, 32'h0}           // R7 unarmed
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic pulse_done(input logic [31:0] b);
        @(negedge clk);
        dma_done = 1'b1; dma_bytes = b;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        drv_can_write = 1'b1; drv_status = 8'h5A; dma_done = 1'b0; dma_bytes = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 dma_req", {31'b0, dma_req}, 32'h0);
        check("R1 cmd_valid", {31'b0, cmd_valid}, 32'h0);
        check("R1 tf_lba", {8'b0, tf_lba}, 32'h0);
        for (int a = 8; a <= 13; a++) read_chk("R1 dma regs", 4'(a), 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) do_write(VEC[i][71:68], VEC[i][67:36]);
            else @(negedge clk);
            read_chk($sformatf("vec%0d", i), VEC[i][35:32], VEC[i][31:0]);
        end
        check("R4 tf_feature port", {24'b0, tf_feature}, 32'hC3);

        // R4: drive refuses writes
        drv_can_write = 1'b0;
        do_write(4'd1, 32'h99);
        read_chk("R4 refused count", 4'd1, 32'h0);

        // R5: refused non-nop command, then nop accepted
        @(negedge clk); wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'h20;
        @(negedge clk); wr_en = 1'b0;
        check("R5 refused cmd", {31'b0, cmd_valid}, 32'h0);
        @(negedge clk); wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'h00;
        @(negedge clk); wr_en = 1'b0;
        check("R5 nop strobe", {31'b0, cmd_valid}, 32'h1);
        @(negedge clk);
        check("R5 strobe one cycle", {31'b0, cmd_valid}, 32'h0);
        drv_can_write = 1'b1;
        @(negedge clk); wr_en = 1'b1; wr_addr = 4'd6; wr_data = 32'hFFEC;
        @(negedge clk); wr_en = 1'b0;
        check("R5 cmd strobe", {31'b0, cmd_valid}, 32'h1);
        check("R5 cmd code", {24'b0, cmd_code}, 32'hEC);

        // R6: armed start
        do_write(4'd11, 32'h1);
        do_write(4'd12, 32'h1);
        check("R6 req", {31'b0, dma_req}, 32'h1);
        read_chk("R6 moved cleared", 4'd13, 32'h0);

        // R9: writes ignored during transfer
        do_write(4'd8, 32'hDEAD_0000);
        read_chk("R9 addr held", 4'd8, 32'h8000_1000);
        check("R9 dma_addr port", dma_addr, 32'h8000_1000);
        do_write(4'd12, 32'h0);
        check("R9 go held", {31'b0, dma_req}, 32'h1);
        do_write(4'd11, 32'h0);
        read_chk("R9 arm held", 4'd11, 32'h1);
        repeat (3) @(negedge clk);
        check("R6 req holds", {31'b0, dma_req}, 32'h1);

        // R8: completion
        pulse_done(32'h1F0);
        check("R8 req low", {31'b0, dma_req}, 32'h0);
        read_chk("R8 moved", 4'd13, 32'h1F0);
        read_chk("R8 go zero", 4'd12, 32'h0);

        // R8: idle done ignored
        pulse_done(32'h77);
        read_chk("R8 idle done", 4'd13, 32'h1F0);

        // R6: restart clears moved count
        do_write(4'd12, 32'h1);
        read_chk("R6 restart cleared", 4'd13, 32'h0);
        pulse_done(32'h40);
        read_chk("R8 second count", 4'd13, 32'h40);

        // R7: go value other than 1 starts nothing
        do_write(4'd12, 32'h3);
        check("R7 non-one go", {31'b0, dma_req}, 32'h0);

        // R1: reset again restores closed gate
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        read_chk("R1 gate after reset", 4'd14, 32'h0);
        read_chk("R1 moved after reset", 4'd13, 32'h0);

        finish_run();
    end

endmodule